// File: doc/BRIEF.md
# Trap-Return Status Unit

This unit carries out the two privileged return instructions of a processor core: the supervisor return and the machine return. One request is presented per cycle with a single-bit `req_mret` select. The unit takes the current privilege level, the virtualization flag, the status and hypervisor-status words, both saved exception PCs and the configuration flags for the compressed extension, the hypervisor extension and the presence of protection rules. One cycle later it returns a registered verdict.

A legal return pops the interrupt-enable stack in the status word and gives the new status and hypervisor-status words, the return PC, the new privilege and the new virtualization mode. When the return re-enters a virtualized context it also raises a one-cycle bank-swap pulse. A failed check produces a fault flag and a five-bit cause code instead, and every state output then repeats its input unchanged.

Privilege encoding is U = 0, S = 1, M = 3. The status bit positions are: supervisor enable at 1, machine enable at 3, supervisor previous-enable at 5, machine previous-enable at 7, supervisor previous-privilege at 8, machine previous-privilege at 12:11, return trap at 22 and machine previous-virtualization at 39. In the hypervisor-status word, the supervisor previous-virtualization bit is 7 and the virtual return trap is 22. The cause codes are misaligned = 0, illegal = 2 and virtual-instruction = 22.

Top module: `trap_return_unit`

## Requirements
- R1: The response is registered. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high and low otherwise. `swap_pulse` is never high outside such a cycle. Reset (`rst_n` low) clears every output to zero.
- R2: A supervisor return issued at privilege U faults with cause 2. This check wins over every other check.
- R3: With `has_c` low, a return whose target PC (`sepc_in` or `mepc_in`) has bit 1 or bit 0 set faults with cause 0. This check ranks just after the privilege check and before the remaining checks.
- R4: A supervisor return with status bit 22 set faults with cause 2 unless the current privilege is M.
- R5: A supervisor return with `has_h` high, `cur_virt` high and hypervisor-status bit 22 set faults with cause 22.
- R6: A legal supervisor return copies status bit 5 into bit 1, sets bit 5 and clears bit 8. The new privilege is the old bit 8 (U or S) and `next_pc` is `sepc_in`.
- R7: On a legal supervisor return with `has_h` high and `cur_virt` low, the new virtualization is the old hypervisor-status bit 7 and that bit is cleared. `swap_pulse` is raised when the old bit 7 was 1. Otherwise virtualization and the hypervisor-status word pass through unchanged.
- R8: A machine return issued at a privilege other than M faults with cause 2.
- R9: A machine return with `pmp_present` low and status bits 12:11 not equal to 3 faults with cause 2.
- R10: A legal machine return copies status bit 7 into bit 3, sets bit 7, and clears bits 12:11 and bit 39. The new privilege is the old bits 12:11 and `next_pc` is `mepc_in`. With `has_h` high, the new virtualization is the old bit 39 and `swap_pulse` is raised when that bit was 1. With `has_h` low, `cur_virt` passes through.
- R11: On a fault, `status_out`, `hstatus_out`, `next_priv` and `next_virt` equal their inputs, `next_pc` is zero and `swap_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Return request this cycle |
| req_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Virtualization currently active |
| status_in | input | 64 | Current status word |
| hstatus_in | input | 64 | Current hypervisor-status word |
| sepc_in | input | 64 | Supervisor exception PC |
| mepc_in | input | 64 | Machine exception PC |
| has_c | input | 1 | Compressed extension present |
| has_h | input | 1 | Hypervisor extension present |
| pmp_present | input | 1 | At least one protection rule configured |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | The return raised an exception |
| rsp_cause | output | 5 | Exception cause code |
| status_out | output | 64 | Updated status word |
| hstatus_out | output | 64 | Updated hypervisor-status word |
| next_pc | output | 64 | Return target, zero on fault |
| next_priv | output | 2 | New privilege level |
| next_virt | output | 1 | New virtualization mode |
| swap_pulse | output | 1 | One-cycle request to swap hypervisor register banks |

## Verification
The assertions use `$past` to compare each response with the request one cycle earlier. They therefore assume the request inputs are sampled only in the request cycle and may change freely afterwards. The bench keeps to this by applying each request for exactly one cycle at the falling edge and reading the response at the next falling edge. The stimulus uses only the legal privilege encodings 0, 1 and 3. It sets `cur_virt` only together with a privilege below M, so the virtualized cases stay on states a core can really reach.

// File: rtl/trap_ret_pkg.sv
// Package for the trap-return unit: word widths, status bit positions,
// privilege encodings and cause codes. Assumes a 64-bit status layout.
package trap_ret_pkg;
    localparam int ST_W  = 64;
    localparam int PC_W  = 64;
    localparam int CAUSE_W = 5;

    // status word bit positions
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = 12;
    localparam int B_TSR  = 22;
    localparam int B_MPV  = 39;

    // hypervisor-status word bit positions
    localparam int B_SPV  = 7;
    localparam int B_VTSR = 22;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic                fault;
        logic [CAUSE_W-1:0]  cause;
    } verdict_t;
endpackage

// File: rtl/trap_ret_check.sv
// Legality checker for trap returns. Purely combinational.
// Evaluates the checks in fixed priority and reports the first that fails.
// Assumes the caller has already muxed the proper return target.
module trap_ret_check
    import trap_ret_pkg::*;
(
    input  logic       is_mret,
    input  logic [1:0] cur_priv,
    input  logic       cur_virt,
    input  logic       tsr,
    input  logic       vtsr,
    input  logic [1:0] mpp,
    input  logic [1:0] target_lo,
    input  logic       has_c,
    input  logic       has_h,
    input  logic       pmp_present,
    output verdict_t   verdict
);
    logic misaligned;

    // Purpose: flag a target that is not 4-byte aligned when compressed is absent.
    always_comb misaligned = !has_c && (target_lo != 2'b00);

    // Purpose: priority chain of return checks; first failure sets the cause.
    always_comb begin
        verdict = '{fault: 1'b0, cause: CAUSE_MISALIGN};
        if (!is_mret) begin
            if (cur_priv == PRIV_U) begin
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (misaligned) begin
                verdict = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            end else if (tsr && (cur_priv != PRIV_M)) begin
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (has_h && cur_virt && vtsr) begin
                verdict = '{fault: 1'b1, cause: CAUSE_VIRT};
            end
        end else begin
            if (cur_priv != PRIV_M) begin
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end else if (misaligned) begin
                verdict = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            end else if (!pmp_present && (mpp != PRIV_M)) begin
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            end
        end
    end
endmodule

// File: rtl/trap_ret_update.sv
// State update for a legal trap return. Purely combinational.
// Pops the enable stack, picks the new privilege and virtualization mode,
// and flags a bank swap. Assumes the result is discarded on a fault.
module trap_ret_update
    import trap_ret_pkg::*;
(
    input  logic            is_mret,
    input  logic            cur_virt,
    input  logic            has_h,
    input  logic [ST_W-1:0] status,
    input  logic [ST_W-1:0] hstatus,
    output logic [ST_W-1:0] new_status,
    output logic [ST_W-1:0] new_hstatus,
    output logic [1:0]      new_priv,
    output logic            new_virt,
    output logic            swap
);
    // Purpose: compute the post-return status, hypervisor-status and mode.
    always_comb begin
        new_status  = status;
        new_hstatus = hstatus;
        new_virt    = cur_virt;
        swap        = 1'b0;
        if (!is_mret) begin
            new_status[B_SIE]  = status[B_SPIE];
            new_status[B_SPIE] = 1'b1;
            new_status[B_SPP]  = 1'b0;
            new_priv           = {1'b0, status[B_SPP]};
            if (has_h && !cur_virt) begin
                new_hstatus[B_SPV] = 1'b0;
                new_virt           = hstatus[B_SPV];
                swap               = hstatus[B_SPV];
            end
        end else begin
            new_status[B_MIE]               = status[B_MPIE];
            new_status[B_MPIE]              = 1'b1;
            new_status[B_MPP_HI:B_MPP_LO]   = PRIV_U;
            new_status[B_MPV]               = 1'b0;
            new_priv                        = status[B_MPP_HI:B_MPP_LO];
            if (has_h) begin
                new_virt = status[B_MPV];
                swap     = status[B_MPV];
            end
        end
    end
endmodule

// File: rtl/trap_return_unit.sv
// Top of the trap-return unit. Selects the return target, runs the legality
// checks and the state update, and registers one response per request.
// Assumes requests arrive at most one per cycle; outputs hold between them
// except rsp_valid and swap_pulse, which are single-cycle.
module trap_return_unit
    import trap_ret_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_mret,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic [ST_W-1:0]    status_in,
    input  logic [ST_W-1:0]    hstatus_in,
    input  logic [PC_W-1:0]    sepc_in,
    input  logic [PC_W-1:0]    mepc_in,
    input  logic               has_c,
    input  logic               has_h,
    input  logic               pmp_present,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [ST_W-1:0]    status_out,
    output logic [ST_W-1:0]    hstatus_out,
    output logic [PC_W-1:0]    next_pc,
    output logic [1:0]         next_priv,
    output logic               next_virt,
    output logic               swap_pulse
);
    logic [PC_W-1:0] target;
    verdict_t        verdict;
    logic [ST_W-1:0] upd_status, upd_hstatus;
    logic [1:0]      upd_priv;
    logic            upd_virt, upd_swap;

    // Purpose: pick the saved PC that matches the return type.
    always_comb target = req_mret ? mepc_in : sepc_in;

    trap_ret_check u_check (
        .is_mret     (req_mret),
        .cur_priv    (cur_priv),
        .cur_virt    (cur_virt),
        .tsr         (status_in[B_TSR]),
        .vtsr        (hstatus_in[B_VTSR]),
        .mpp         (status_in[B_MPP_HI:B_MPP_LO]),
        .target_lo   (target[1:0]),
        .has_c       (has_c),
        .has_h       (has_h),
        .pmp_present (pmp_present),
        .verdict     (verdict)
    );

    trap_ret_update u_update (
        .is_mret     (req_mret),
        .cur_virt    (cur_virt),
        .has_h       (has_h),
        .status      (status_in),
        .hstatus     (hstatus_in),
        .new_status  (upd_status),
        .new_hstatus (upd_hstatus),
        .new_priv    (upd_priv),
        .new_virt    (upd_virt),
        .swap        (upd_swap)
    );

    // Purpose: register the verdict and, only when legal, the new state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_cause   <= '0;
            status_out  <= '0;
            hstatus_out <= '0;
            next_pc     <= '0;
            next_priv   <= PRIV_U;
            next_virt   <= 1'b0;
            swap_pulse  <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            swap_pulse <= 1'b0;
            if (req_valid) begin
                rsp_fault <= verdict.fault;
                rsp_cause <= verdict.cause;
                if (verdict.fault) begin
                    status_out  <= status_in;
                    hstatus_out <= hstatus_in;
                    next_pc     <= '0;
                    next_priv   <= cur_priv;
                    next_virt   <= cur_virt;
                end else begin
                    status_out  <= upd_status;
                    hstatus_out <= upd_hstatus;
                    next_pc     <= target;
                    next_priv   <= upd_priv;
                    next_virt   <= upd_virt;
                    swap_pulse  <= upd_swap;
                end
            end
        end
    end
endmodule

// File: rtl/trap_return_checker.sv
// Assertion checker for the trap-return unit, bound to every instance.
// Assumes request inputs are only meaningful in the request cycle.
module trap_return_checker
    import trap_ret_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_mret,
    input logic [1:0]         cur_priv,
    input logic [ST_W-1:0]    status_in,
    input logic [ST_W-1:0]    hstatus_in,
    input logic [PC_W-1:0]    sepc_in,
    input logic [PC_W-1:0]    mepc_in,
    input logic               has_c,
    input logic               has_h,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [CAUSE_W-1:0] rsp_cause,
    input logic [ST_W-1:0]    status_out,
    input logic [ST_W-1:0]    hstatus_out,
    input logic [PC_W-1:0]    next_pc,
    input logic [1:0]         next_priv,
    input logic               swap_pulse
);
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_swap_only_on_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (rsp_valid && !rsp_fault && $past(has_h)));
    assert_sret_from_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_mret) && $past(cur_priv) == PRIV_U)
        |-> (rsp_fault && rsp_cause == CAUSE_ILLEGAL));
    assert_mret_below_machine_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_mret) && $past(cur_priv) != PRIV_M)
        |-> (rsp_fault && rsp_cause == CAUSE_ILLEGAL));
    assert_aligned_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !$past(has_c)) |-> (next_pc[1:0] == 2'b00));
    assert_fault_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault)
        |-> (status_out == $past(status_in) && hstatus_out == $past(hstatus_in)
             && next_priv == $past(cur_priv) && !swap_pulse));
    assert_sret_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !$past(req_mret))
        |-> (status_out[B_SPIE] && !status_out[B_SPP]
             && next_priv == {1'b0, $past(status_in[B_SPP])}
             && next_pc == $past(sepc_in)));
    assert_mret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(req_mret))
        |-> (status_out[B_MPIE] && status_out[B_MPP_HI:B_MPP_LO] == PRIV_U
             && !status_out[B_MPV]
             && next_priv == $past(status_in[B_MPP_HI:B_MPP_LO])
             && next_pc == $past(mepc_in)));
endmodule

bind trap_return_unit trap_return_checker u_chk (.*);

// File: tb/trap_return_unit_test.sv
// Bench for the trap-return unit: a vector table walked by one loop,
// then directed checks for reset and idle behaviour.
module trap_return_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_mret = 1'b0;
    logic [1:0]  cur_priv = 2'd0;
    logic        cur_virt = 1'b0;
    logic [63:0] status_in = '0, hstatus_in = '0, sepc_in = '0, mepc_in = '0;
    logic        has_c = 1'b0, has_h = 1'b0, pmp_present = 1'b0;
    logic        rsp_valid, rsp_fault, next_virt, swap_pulse;
    logic [4:0]  rsp_cause;
    logic [63:0] status_out, hstatus_out, next_pc;
    logic [1:0]  next_priv;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    trap_return_unit uut (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic        mret;
        logic [1:0]  priv;
        logic        virt;
        logic        c;
        logic        h;
        logic        pmp;
        logic [63:0] st;
        logic [63:0] hst;
        logic [63:0] sepc;
        logic [63:0] mepc;
        logic        e_fault;
        logic [4:0]  e_cause;
        logic [1:0]  e_priv;
        logic        e_virt;
        logic        e_swap;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R6 plain sret from S, SPIE=1
        '{8'd6, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h20, 64'h0, 64'h1002, 64'h0, 1'b0, 5'd0, 2'd0, 1'b0, 1'b0},
        // R4 trap bit ignored at M; SPP=1 gives S
        '{8'd4, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h400100, 64'h0, 64'h3000, 64'h0, 1'b0, 5'd0, 2'd1, 1'b0, 1'b0},
        // R4 trap bit at S
        '{8'd4, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h400000, 64'h0, 64'h3000, 64'h0, 1'b1, 5'd2, 2'd1, 1'b0, 1'b0},
        // R2 sret from U
        '{8'd2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h20, 64'h0, 64'h3000, 64'h0, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},
        // R2 beats misalignment
        '{8'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 64'h1002, 64'h0, 1'b1, 5'd2, 2'd0, 1'b0, 1'b0},
        // R3 misaligned sret
        '{8'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 64'h1002, 64'h0, 1'b1, 5'd0, 2'd1, 1'b0, 1'b0},
        // R3 misalignment beats trap bit
        '{8'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h400000, 64'h0, 64'h1001, 64'h0, 1'b1, 5'd0, 2'd1, 1'b0, 1'b0},
        // R5 virtual trap
        '{8'd5, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0, 64'h400000, 64'h3000, 64'h0, 1'b1, 5'd22, 2'd1, 1'b1, 1'b0},
        // R7 SPV=1 enters virtualization with swap
        '{8'd7, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h100, 64'h80, 64'h3000, 64'h0, 1'b0, 5'd0, 2'd1, 1'b1, 1'b1},
        // R7 SPV=0 no swap
        '{8'd7, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h400000, 64'h3000, 64'h0, 1'b0, 5'd0, 2'd0, 1'b0, 1'b0},
        // R7 no hypervisor: virt and SPV untouched
        '{8'd7, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 64'h400080, 64'h3000, 64'h0, 1'b0, 5'd0, 2'd0, 1'b1, 1'b0},
        // R9 no rules, MPP=S
        '{8'd9, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h880, 64'h0, 64'h0, 64'h4000, 1'b1, 5'd2, 2'd3, 1'b0, 1'b0},
        // R10 rules present, MPP=S
        '{8'd10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h880, 64'h0, 64'h0, 64'h4000, 1'b0, 5'd0, 2'd1, 1'b0, 1'b0},
        // R9 no rules but MPP=M is legal
        '{8'd9, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h1800, 64'h0, 64'h0, 64'h4000, 1'b0, 5'd0, 2'd3, 1'b0, 1'b0},
        // R8 mret from S
        '{8'd8, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1800, 64'h0, 64'h0, 64'h4000, 1'b1, 5'd2, 2'd1, 1'b0, 1'b0},
        // R3 misaligned mret
        '{8'd3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1800, 64'h0, 64'h0, 64'h2001, 1'b1, 5'd0, 2'd3, 1'b0, 1'b0},
        // R10 MPV=1 with hypervisor: swap
        '{8'd10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000000880, 64'h0, 64'h0, 64'h4000, 1'b0, 5'd0, 2'd1, 1'b1, 1'b1},
        // R10 MPV=1 without hypervisor: virt stays, MPV cleared
        '{8'd10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h8000001808, 64'h0, 64'h0, 64'h4000, 1'b0, 5'd0, 2'd3, 1'b0, 1'b0},
        // R7 hypervisor, virt on, no trap: hstatus kept, virt stays
        '{8'd7, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h122, 64'h80, 64'h3000, 64'h0, 1'b0, 5'd0, 2'd1, 1'b1, 1'b0}
    };

    task automatic check64(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected status word from R6 / R10 (or unchanged per R11)
    function automatic logic [63:0] exp_status(input vec_t v);
        logic [63:0] s = v.st;
        if (v.e_fault) return s;
        if (!v.mret) begin
            s[1] = v.st[5]; s[5] = 1'b1; s[8] = 1'b0;
        end else begin
            s[3] = v.st[7]; s[7] = 1'b1; s[12:11] = 2'b00; s[39] = 1'b0;
        end
        return s;
    endfunction

    // Expected hypervisor-status word from R7 (or unchanged per R11)
    function automatic logic [63:0] exp_hstatus(input vec_t v);
        logic [63:0] h = v.hst;
        if (!v.e_fault && !v.mret && v.h && !v.virt) h[7] = 1'b0;
        return h;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check64("reset rsp_valid", 1, {63'd0, rsp_valid}, 64'd0);
        check64("reset status_out", 1, status_out, 64'd0);
        check64("reset next_pc", 1, next_pc, 64'd0);
        check64("reset swap_pulse", 1, {63'd0, swap_pulse}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("idle rsp_valid", 1, {63'd0, rsp_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            req_valid = 1'b1; req_mret = v.mret; cur_priv = v.priv; cur_virt = v.virt;
            has_c = v.c; has_h = v.h; pmp_present = v.pmp;
            status_in = v.st; hstatus_in = v.hst; sepc_in = v.sepc; mepc_in = v.mepc;
            @(negedge clk);
            req_valid = 1'b0;
            status_in = ~v.st; hstatus_in = ~v.hst; sepc_in = '0; mepc_in = '0;
            check64("rsp_valid (R1)", v.req, {63'd0, rsp_valid}, 64'd1);
            check64("fault", v.req, {63'd0, rsp_fault}, {63'd0, v.e_fault});
            if (v.e_fault) check64("cause", v.req, {59'd0, rsp_cause}, {59'd0, v.e_cause});
            check64("status_out", v.req, status_out, exp_status(v));
            check64("hstatus_out", v.req, hstatus_out, exp_hstatus(v));
            check64("next_pc", v.req, next_pc,
                    v.e_fault ? 64'd0 : (v.mret ? v.mepc : v.sepc));
            check64("next_priv", v.req, {62'd0, next_priv}, {62'd0, v.e_priv});
            check64("next_virt", v.req, {63'd0, next_virt}, {63'd0, v.e_virt});
            check64("swap_pulse", v.req, {63'd0, swap_pulse}, {63'd0, v.e_swap});
        end

        // R1: one idle cycle drops rsp_valid and swap, state holds
        @(negedge clk);
        check64("idle after rsp rsp_valid", 1, {63'd0, rsp_valid}, 64'd0);
        check64("idle after rsp swap_pulse", 1, {63'd0, swap_pulse}, 64'd0);
        check64("idle hold status_out", 1, status_out, exp_status(VECS[NV-1]));

        // R7 swap pulse lasts one cycle: rerun swap vector then idle
        req_valid = 1'b1; req_mret = 1'b0; cur_priv = 2'd1; cur_virt = 1'b0;
        has_c = 1'b1; has_h = 1'b1; pmp_present = 1'b1;
        status_in = 64'h100; hstatus_in = 64'h80; sepc_in = 64'h5000;
        @(negedge clk);
        req_valid = 1'b0;
        check64("swap high", 7, {63'd0, swap_pulse}, 64'd1);
        @(negedge clk);
        check64("swap one cycle", 7, {63'd0, swap_pulse}, 64'd0);

        // R1 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check64("re-reset next_pc", 1, next_pc, 64'd0);
        check64("re-reset next_virt", 1, {63'd0, next_virt}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule